// File: doc/BRIEF.md
# Phase-Interleaved Shared SRAM Switch

This block lets one video scan-out reader and three processors share a single-port SRAM. The memory clock runs at twice the video rate. The block makes its own video clock by toggling a phase bit on every memory cycle. In the high phase the video reader owns the memory: its address goes to the SRAM and no write can happen. In the low phase one processor may use the memory. Processors are served in fixed priority order, and processor 0 ranks highest.

A processor first sets up its address, its data, its read/write flag, its width flag and its byte-lane select. It then raises its request and waits for acknowledge. Acknowledge and any read data arrive together at the end of the low phase in which that processor was served. The processor then drops its request, and acknowledge clears one cycle later. Pixel traffic uses byte writes. Shared variables use 16-bit words and are normally kept in the undisplayed word range 246400 to 262143. Reset outranks every other user of the memory.

Top module: `shared_sram_switch`

## Requirements
- R1: While rst_n is low, vid_clk is 1, sram_we is 0, every cpu_ack bit is 0, and vid_data and every cpu_rdata word are 0.
- R2: After reset, vid_clk inverts on every clock edge, and the first cycle after reset is a video cycle (vid_clk=1). In every cycle with vid_clk=1, sram_addr equals vid_addr.
- R3: The value on sram_rdata at the end of a cycle with vid_clk=1 appears on vid_data after that edge. vid_data then holds unchanged until the end of the next video cycle.
- R4: In a cycle with vid_clk=0, the switch serves the lowest-numbered processor that has its request high and its acknowledge low, and drives that processor's address onto sram_addr.
- R5: sram_we is 1 only in a cycle with vid_clk=0 in which a processor is served and that processor's cpu_we is 1. It is 0 in every other cycle.
- R6: A served word write (cpu_wide=1) drives sram_be=2'b11 and the full data word. A served byte write (cpu_wide=0) drives cpu_wdata[7:0] onto both halves of sram_wdata and enables one lane: sram_be=2'b10 when cpu_lane=1 (bits 15:8), and 2'b01 when cpu_lane=0 (bits 7:0).
- R7: At the end of the low cycle that serves a processor, that processor's cpu_rdata loads the SRAM read data. For a word access it takes the whole word. For a byte access it takes the lane chosen by cpu_lane, zero-extended. Every other processor's cpu_rdata keeps its value.
- R8: cpu_ack stays 1 for as long as that processor holds its request high. It is 0 on the first edge after the request is seen low. A processor whose cpu_ack is 1 is never served.
- R9: cpu_ack rises only at the end of a cycle in which that processor was served, so at most one acknowledge rises per edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock, twice the video rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| vid_clk | output | 1 | Phase bit; 1 means video phase |
| vid_addr | input | AW | Scan-out address |
| vid_data | output | DW | Registered scan-out read data |
| cpu_req | input | NCPU | Request, one bit per processor |
| cpu_we | input | NCPU | 1 means write |
| cpu_wide | input | NCPU | 1 means 16-bit word, 0 means byte |
| cpu_lane | input | NCPU | Byte lane for byte access, 1 means upper |
| cpu_addr | input | NCPU*AW | Word addresses, processor i in slice i |
| cpu_wdata | input | NCPU*DW | Write data, processor i in slice i |
| cpu_ack | output | NCPU | Acknowledge, one bit per processor |
| cpu_rdata | output | NCPU*DW | Registered read data per processor |
| sram_addr | output | AW | SRAM address |
| sram_wdata | output | DW | SRAM write data |
| sram_be | output | 2 | SRAM lane enables, bit 1 is the upper lane |
| sram_we | output | 1 | SRAM write strobe |
| sram_rdata | input | DW | SRAM read data, asynchronous |

## Verification
The bench raises requests from all three processors in the same low phase, so a priority chain built the wrong way round would serve processor 2 first and put the wrong address on the memory. It holds requests high after acknowledge to catch a switch that serves the same processor again or drops acknowledge early. It also releases and re-requests at once, so a switch that never clears acknowledge stalls, and the watchdog catches that. Directed byte writes into both lanes of one shared word, followed by word and byte reads from other processors, expose swapped lane enables, a missing zero extension, and read data written into the wrong processor's register. A cycle-by-cycle reference model checks that no write escapes into a video cycle and that vid_data changes only after video cycles.

// File: rtl/sss_pkg.sv
package sss_pkg;

   typedef enum logic {
      PH_CPU   = 1'b0,
      PH_VIDEO = 1'b1
   } phase_e;

   function automatic logic [1:0] lane_enables(input logic wide, input logic lane);
      if (wide)
         return 2'b11;
      else if (lane)
         return 2'b10;
      else
         return 2'b01;
   endfunction

endpackage

// File: rtl/sss_phase.sv
module sss_phase (
   input  logic clk,
   input  logic rst_n,
   output logic video_ph
);
   import sss_pkg::*;

   phase_e ph_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ph_q <= PH_VIDEO;
      else if (ph_q == PH_VIDEO)
         ph_q <= PH_CPU;
      else
         ph_q <= PH_VIDEO;
   end

   assign video_ph = (ph_q == PH_VIDEO);
endmodule

// File: rtl/sss_arb.sv
module sss_arb #(
   parameter int N = 3
) (
   input  logic         en,
   input  logic [N-1:0] pend,
   output logic [N-1:0] gnt,
   output logic         any
);
   generate
      if (N == 1) begin : g_single
         assign gnt = pend & {N{en}};
      end else begin : g_chain
         logic [N-1:0] lower_busy;
         assign lower_busy[0] = 1'b0;
         for (genvar i = 1; i < N; i++) begin : g_link
            assign lower_busy[i] = lower_busy[i-1] | pend[i-1];
         end
         assign gnt = pend & ~lower_busy & {N{en}};
      end
   endgenerate

   assign any = |gnt;
endmodule

// File: rtl/sss_port.sv
module sss_port #(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_i,
   input  logic          grant_i,
   input  logic          wide_i,
   input  logic          lane_i,
   input  logic [DW-1:0] mem_rdata_i,
   output logic          ack_o,
   output logic [DW-1:0] rdata_o
);
   localparam int HW = DW / 2;

   logic          ack_q;
   logic [DW-1:0] rdata_q;
   logic [DW-1:0] shaped;

   always_comb begin
      if (wide_i)
         shaped = mem_rdata_i;
      else if (lane_i)
         shaped = {{(DW-HW){1'b0}}, mem_rdata_i[DW-1:HW]};
      else
         shaped = {{(DW-HW){1'b0}}, mem_rdata_i[HW-1:0]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_q   <= 1'b0;
         rdata_q <= '0;
      end else begin
         if (!req_i)
            ack_q <= 1'b0;
         else if (grant_i)
            ack_q <= 1'b1;
         if (grant_i)
            rdata_q <= shaped;
      end
   end

   assign ack_o   = ack_q;
   assign rdata_o = rdata_q;
endmodule

// File: rtl/sss_mux.sv
module sss_mux #(
   parameter int N  = 3,
   parameter int AW = 18,
   parameter int DW = 16
) (
   input  logic            video_ph,
   input  logic [AW-1:0]   vid_addr,
   input  logic [N-1:0]    gnt,
   input  logic            gnt_any,
   input  logic [N-1:0]    cpu_we,
   input  logic [N-1:0]    cpu_wide,
   input  logic [N-1:0]    cpu_lane,
   input  logic [N*AW-1:0] cpu_addr,
   input  logic [N*DW-1:0] cpu_wdata,
   output logic [AW-1:0]   mem_addr,
   output logic [DW-1:0]   mem_wdata,
   output logic [1:0]      mem_be,
   output logic            mem_we
);
   import sss_pkg::*;
   localparam int HW = DW / 2;

   logic [AW-1:0] sel_addr;
   logic [DW-1:0] sel_data;
   logic          sel_we;
   logic          sel_wide;
   logic          sel_lane;

   always_comb begin
      sel_addr = '0;
      sel_data = '0;
      sel_we   = 1'b0;
      sel_wide = 1'b0;
      sel_lane = 1'b0;
      for (int i = 0; i < N; i++) begin
         if (gnt[i]) begin
            sel_addr = cpu_addr[i*AW +: AW];
            sel_data = cpu_wdata[i*DW +: DW];
            sel_we   = cpu_we[i];
            sel_wide = cpu_wide[i];
            sel_lane = cpu_lane[i];
         end
      end
   end

   always_comb begin
      if (video_ph || !gnt_any) begin
         mem_addr  = vid_addr;
         mem_wdata = '0;
         mem_be    = 2'b00;
         mem_we    = 1'b0;
      end else begin
         mem_addr  = sel_addr;
         mem_wdata = sel_wide ? sel_data : {sel_data[HW-1:0], sel_data[HW-1:0]};
         mem_be    = sel_we ? lane_enables(sel_wide, sel_lane) : 2'b00;
         mem_we    = sel_we;
      end
   end
endmodule

// File: rtl/shared_sram_switch.sv
module shared_sram_switch #(
   parameter int AW   = 18,
   parameter int DW   = 16,
   parameter int NCPU = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   output logic               vid_clk,
   input  logic [AW-1:0]      vid_addr,
   output logic [DW-1:0]      vid_data,
   input  logic [NCPU-1:0]    cpu_req,
   input  logic [NCPU-1:0]    cpu_we,
   input  logic [NCPU-1:0]    cpu_wide,
   input  logic [NCPU-1:0]    cpu_lane,
   input  logic [NCPU*AW-1:0] cpu_addr,
   input  logic [NCPU*DW-1:0] cpu_wdata,
   output logic [NCPU-1:0]    cpu_ack,
   output logic [NCPU*DW-1:0] cpu_rdata,
   output logic [AW-1:0]      sram_addr,
   output logic [DW-1:0]      sram_wdata,
   output logic [1:0]         sram_be,
   output logic               sram_we,
   input  logic [DW-1:0]      sram_rdata
);
   generate
      if (DW < 2 || (DW % 2) != 0) begin : g_bad_dw
         $error("shared_sram_switch: DW must be even and at least 2");
      end
      if (AW < 1) begin : g_bad_aw
         $error("shared_sram_switch: AW must be positive");
      end
      if (NCPU < 1) begin : g_bad_n
         $error("shared_sram_switch: NCPU must be positive");
      end
   endgenerate

   logic              video_ph;
   logic [NCPU-1:0]   pend;
   logic [NCPU-1:0]   gnt;
   logic              gnt_any;
   logic              mux_we;
   logic [DW-1:0]     vid_q;

   sss_phase u_phase (
      .clk      (clk),
      .rst_n    (rst_n),
      .video_ph (video_ph)
   );

   assign pend = cpu_req & ~cpu_ack;

   sss_arb #(.N(NCPU)) u_arb (
      .en   (!video_ph && rst_n),
      .pend (pend),
      .gnt  (gnt),
      .any  (gnt_any)
   );

   for (genvar i = 0; i < NCPU; i++) begin : g_port
      sss_port #(.DW(DW)) u_port (
         .clk         (clk),
         .rst_n       (rst_n),
         .req_i       (cpu_req[i]),
         .grant_i     (gnt[i]),
         .wide_i      (cpu_wide[i]),
         .lane_i      (cpu_lane[i]),
         .mem_rdata_i (sram_rdata),
         .ack_o       (cpu_ack[i]),
         .rdata_o     (cpu_rdata[i*DW +: DW])
      );
   end

   sss_mux #(.N(NCPU), .AW(AW), .DW(DW)) u_mux (
      .video_ph  (video_ph),
      .vid_addr  (vid_addr),
      .gnt       (gnt),
      .gnt_any   (gnt_any),
      .cpu_we    (cpu_we),
      .cpu_wide  (cpu_wide),
      .cpu_lane  (cpu_lane),
      .cpu_addr  (cpu_addr),
      .cpu_wdata (cpu_wdata),
      .mem_addr  (sram_addr),
      .mem_wdata (sram_wdata),
      .mem_be    (sram_be),
      .mem_we    (mux_we)
   );

   assign sram_we = mux_we && rst_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         vid_q <= '0;
      else if (video_ph)
         vid_q <= sram_rdata;
   end

   assign vid_data = vid_q;
   assign vid_clk  = video_ph;
endmodule

// File: rtl/sss_checker.sv
module sss_checker #(
   parameter int AW   = 18,
   parameter int DW   = 16,
   parameter int NCPU = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic               vid_clk,
   input logic [AW-1:0]      vid_addr,
   input logic [DW-1:0]      vid_data,
   input logic [NCPU-1:0]    cpu_req,
   input logic [NCPU-1:0]    cpu_we,
   input logic [NCPU-1:0]    cpu_wide,
   input logic [NCPU-1:0]    cpu_lane,
   input logic [NCPU*AW-1:0] cpu_addr,
   input logic [NCPU*DW-1:0] cpu_wdata,
   input logic [NCPU-1:0]    cpu_ack,
   input logic [NCPU*DW-1:0] cpu_rdata,
   input logic [AW-1:0]      sram_addr,
   input logic [DW-1:0]      sram_wdata,
   input logic [1:0]         sram_be,
   input logic               sram_we,
   input logic [DW-1:0]      sram_rdata
);
   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |-> (!sram_we && cpu_ack == '0));

   assert_phase_alt_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (vid_clk != $past(vid_clk)));

   assert_video_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      vid_clk |-> (sram_addr == vid_addr));

   assert_vid_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !vid_clk |=> $stable(vid_data));

   assert_we_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
      sram_we |-> (!vid_clk && (cpu_req & ~cpu_ack) != '0));

   assert_ack_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_ack & cpu_req) != '0 |=> ((($past(cpu_ack) & $past(cpu_req)) & ~cpu_ack) == '0));

   assert_ack_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_ack & ~cpu_req) != '0 |=> ((cpu_ack & ~$past(cpu_req)) == '0));

   assert_one_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cpu_ack & ~$past(cpu_ack)));

   assert_rise_after_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_ack & ~$past(cpu_ack)) != '0 |-> vid_clk);
endmodule

bind shared_sram_switch sss_checker #(.AW(AW), .DW(DW), .NCPU(NCPU)) u_chk (.*);

// File: tb/sim_shared_sram_switch.sv
module sim_shared_sram_switch;
   localparam int CLK_P = 10;
   localparam int AW = 18;
   localparam int DW = 16;
   localparam int N  = 3;
   localparam int MW = 1024;
   localparam int SHARED_BASE = 246400;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic vid_clk;
   logic [AW-1:0] vid_addr = '0;
   logic [DW-1:0] vid_data;
   logic [N-1:0] cpu_req, cpu_we, cpu_wide, cpu_lane, cpu_ack;
   logic [N*AW-1:0] cpu_addr;
   logic [N*DW-1:0] cpu_wdata, cpu_rdata;
   logic [AW-1:0] sram_addr;
   logic [DW-1:0] sram_wdata, sram_rdata;
   logic [1:0] sram_be;
   logic sram_we;

   logic          c_req  [N];
   logic          c_we   [N];
   logic          c_wide [N];
   logic          c_lane [N];
   logic [AW-1:0] c_addr [N];
   logic [DW-1:0] c_wd   [N];

   for (genvar i = 0; i < N; i++) begin : g_drv
      assign cpu_req[i]  = c_req[i];
      assign cpu_we[i]   = c_we[i];
      assign cpu_wide[i] = c_wide[i];
      assign cpu_lane[i] = c_lane[i];
      assign cpu_addr[i*AW +: AW]  = c_addr[i];
      assign cpu_wdata[i*DW +: DW] = c_wd[i];
   end

   logic [DW-1:0] mem [MW];
   logic [DW-1:0] shadow [MW];

   assign sram_rdata = mem[sram_addr[9:0]];

   always @(posedge clk) begin
      if (sram_we) begin
         if (sram_be[0]) mem[sram_addr[9:0]][7:0]  <= sram_wdata[7:0];
         if (sram_be[1]) mem[sram_addr[9:0]][15:8] <= sram_wdata[15:8];
      end
   end

   shared_sram_switch #(.AW(AW), .DW(DW), .NCPU(N)) u0 (.*);

   always #(CLK_P/2) clk = ~clk;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   bit done = 1'b0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected below %0d", cyc, 100000);
         finish_up();
      end
   end

   always @(negedge clk) vid_addr = AW'(SHARED_BASE - 2048 + ($urandom % 4096));

   function automatic logic [DW-1:0] shape(input logic [DW-1:0] w, input logic wide, input logic lane);
      if (wide) return w;
      return lane ? {8'h00, w[15:8]} : {8'h00, w[7:0]};
   endfunction

   // Cycle-by-cycle reference model of the switch, sampled at negedge + 3.
   bit            have_exp = 1'b0;
   logic          e_vclk;
   logic [DW-1:0] e_vid;
   logic [N-1:0]  e_ack;
   logic [DW-1:0] e_rd [N];

   always @(negedge clk) begin
      #3;
      if (!rst_n) begin
         chk(vid_clk == 1'b1, "R1", 32'(vid_clk), 1);
         chk(sram_we == 1'b0, "R1", 32'(sram_we), 0);
         chk(cpu_ack == '0, "R1", 32'(cpu_ack), 0);
         chk(vid_data == '0, "R1", 32'(vid_data), 0);
         chk(cpu_rdata == '0, "R1", 32'(cpu_rdata[31:0]), 0);
         e_vclk = 1'b1;
         e_vid  = '0;
         e_ack  = '0;
         for (int i = 0; i < N; i++) e_rd[i] = '0;
         have_exp = 1'b1;
      end else if (have_exp) begin
         logic [N-1:0] n_ack;
         int g;
         chk(vid_clk == e_vclk, "R2", 32'(vid_clk), 32'(e_vclk));
         chk(vid_data == e_vid, "R3", 32'(vid_data), 32'(e_vid));
         chk(cpu_ack == e_ack, "R8", 32'(cpu_ack), 32'(e_ack));
         for (int i = 0; i < N; i++)
            chk(cpu_rdata[i*DW +: DW] == e_rd[i], "R7", 32'(cpu_rdata[i*DW +: DW]), 32'(e_rd[i]));
         n_ack = e_ack & cpu_req;
         if (vid_clk) begin
            chk(sram_addr == vid_addr, "R2", 32'(sram_addr), 32'(vid_addr));
            chk(sram_we == 1'b0, "R5", 32'(sram_we), 0);
            e_vid = mem[vid_addr[9:0]];
         end else begin
            g = -1;
            for (int i = 0; i < N; i++)
               if (g < 0 && c_req[i] && !e_ack[i]) g = i;
            if (g < 0) begin
               chk(sram_we == 1'b0, "R5", 32'(sram_we), 0);
            end else begin
               chk(sram_addr == c_addr[g], "R4", 32'(sram_addr), 32'(c_addr[g]));
               chk(sram_we == c_we[g], "R5", 32'(sram_we), 32'(c_we[g]));
               if (c_we[g]) begin
                  logic [1:0] xbe;
                  logic [DW-1:0] xwd;
                  xbe = c_wide[g] ? 2'b11 : (c_lane[g] ? 2'b10 : 2'b01);
                  xwd = c_wide[g] ? c_wd[g] : {c_wd[g][7:0], c_wd[g][7:0]};
                  chk(sram_be == xbe, "R6", 32'(sram_be), 32'(xbe));
                  chk(sram_wdata == xwd, "R6", 32'(sram_wdata), 32'(xwd));
               end
               n_ack[g] = 1'b1;
               e_rd[g] = shape(mem[c_addr[g][9:0]], c_wide[g], c_lane[g]);
            end
         end
         e_ack  = n_ack;
         e_vclk = !vid_clk;
      end
   end

   // One handshake for processor i; a read is compared with the shadow when chk_rd is set.
   task automatic cpu_op(input int i, input logic we, input logic wide, input logic lane,
                         input logic [AW-1:0] a, input logic [DW-1:0] d, input bit chk_rd);
      int w;
      @(negedge clk);
      c_we[i] = we; c_wide[i] = wide; c_lane[i] = lane; c_addr[i] = a; c_wd[i] = d;
      c_req[i] = 1'b1;
      w = 0;
      do begin
         @(negedge clk);
         w++;
      end while (!cpu_ack[i] && w < 50);
      chk(cpu_ack[i] == 1'b1, "R9", 32'(cpu_ack[i]), 1);
      if (we) begin
         if (wide) shadow[a[9:0]] = d;
         else if (lane) shadow[a[9:0]][15:8] = d[7:0];
         else shadow[a[9:0]][7:0] = d[7:0];
      end else if (chk_rd) begin
         logic [DW-1:0] x;
         x = shape(shadow[a[9:0]], wide, lane);
         chk(cpu_rdata[i*DW +: DW] == x, "R7", 32'(cpu_rdata[i*DW +: DW]), 32'(x));
      end
      c_req[i] = 1'b0;
   endtask

   task automatic cpu_rand(input int i, input int ops);
      for (int k = 0; k < ops; k++) begin
         int idle;
         idle = $urandom % 4;
         repeat (idle) @(negedge clk);
         cpu_op(i, 1'($urandom), 1'($urandom), 1'($urandom),
                AW'(SHARED_BASE + ($urandom % 32)), DW'($urandom), 1'b0);
      end
   endtask

   initial begin
      void'($urandom(32'd7531));
      for (int k = 0; k < MW; k++) begin mem[k] = '0; shadow[k] = '0; end
      for (int i = 0; i < N; i++) begin
         c_req[i] = 0; c_we[i] = 0; c_wide[i] = 0; c_lane[i] = 0; c_addr[i] = '0; c_wd[i] = '0;
      end
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R6/R7 directed: word write, byte write into upper lane, then reads by other processors
      cpu_op(1, 1'b1, 1'b1, 1'b0, AW'(SHARED_BASE), 16'hA5C3, 1'b0);
      cpu_op(2, 1'b1, 1'b0, 1'b1, AW'(SHARED_BASE), 16'h0077, 1'b0);
      cpu_op(0, 1'b0, 1'b1, 1'b0, AW'(SHARED_BASE), '0, 1'b1);
      cpu_op(2, 1'b0, 1'b0, 1'b1, AW'(SHARED_BASE), '0, 1'b1);
      cpu_op(1, 1'b0, 1'b0, 1'b0, AW'(SHARED_BASE), '0, 1'b1);
      // R6 lower-lane byte write then word read at the top of the address space
      cpu_op(0, 1'b1, 1'b0, 1'b0, AW'(262143), 16'hEE19, 1'b0);
      cpu_op(2, 1'b0, 1'b1, 1'b0, AW'(262143), '0, 1'b1);

      // R4 simultaneous requests: all three raised in one cycle, processor 0 served first
      @(negedge clk);
      for (int i = 0; i < N; i++) begin
         c_we[i] = 1'b0; c_wide[i] = 1'b1; c_addr[i] = AW'(SHARED_BASE + 1 + i); c_req[i] = 1'b1;
      end
      repeat (8) @(negedge clk);
      // R8 all acks held while requests stay high
      chk(cpu_ack == 3'b111, "R8", 32'(cpu_ack), 7);
      for (int i = 0; i < N; i++) c_req[i] = 1'b0;
      @(negedge clk);
      chk(cpu_ack == 3'b000, "R8", 32'(cpu_ack), 0);

      // Random concurrent traffic from all processors
      fork
         cpu_rand(0, 60);
         cpu_rand(1, 60);
         cpu_rand(2, 60);
      join
      repeat (4) @(negedge clk);

      // R1 reset in the middle of operation
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      finish_up();
   end
endmodule